// File: doc/BRIEF.md
# 8-bit accumulator ALU with flags

This block computes one arithmetic or bit-manipulation step on an 8-bit accumulator value and a second 8-bit operand, and produces an 8-bit result together with a new status byte holding sign, zero, nibble carry, parity and carry. The caller supplies the current status byte, so the carry can be chained into add-with-carry and subtract-with-borrow steps, and operations that keep some flags can pass them through.

The result and the status byte are registered. On a clock edge where the write strobe is high, both registers take the newly computed values, so they appear one cycle after the inputs are presented. On an edge where the strobe is low, both registers hold. The block has no storage for the operands themselves and no instruction decoding. The caller selects the operation directly.

Top module: `acc_alu`

## Requirements
- R1: After reset, `result` and `flags_out` are both 00h. In `flags_out`, bits 5, 3 and 1 always read 0. The used flag positions are: bit 7 = S, bit 6 = Z, bit 4 = AC, bit 2 = P and bit 0 = CY.
- R2: `op` = 0 (add) gives `acc_in + opnd_in` and `op` = 1 (add with carry) gives `acc_in + opnd_in + flags_in[0]`. Both are taken modulo 256, and CY is set to the carry out of bit 7.
- R3: `op` = 2 (subtract) gives `acc_in - opnd_in` and `op` = 3 (subtract with borrow) gives `acc_in - opnd_in - flags_in[0]`. Both are taken modulo 256, and CY is 1 exactly when the true difference is negative (a borrow).
- R4: AC is the carry out of bit 3 for add and add with carry. For subtract and subtract with borrow, AC is 1 when the low nibble of `acc_in` is at least the low nibble of `opnd_in` plus the borrow in. For increment, AC is 1 when the low nibble of `acc_in` is Fh. For decrement, AC is 1 when the low nibble of `acc_in` is not 0.
- R5: For operations 0 to 5, S equals bit 7 of the result, Z is 1 when the result is 00h, and P is 1 when the result has an even number of 1 bits.
- R6: `op` = 4 (increment) gives `acc_in + 1` and `op` = 5 (decrement) gives `acc_in - 1`, both modulo 256. For both, CY equals `flags_in[0]`.
- R7: `op` = 6 (complement) gives the bitwise inverse of `acc_in`. For this operation, `flags_out` equals `flags_in` with bits 5, 3 and 1 cleared.
- R8: `op` = 7 (rotate left) gives `{acc_in[6:0], acc_in[7]}` and sets CY to `acc_in[7]`. The other used flags are copied from `flags_in`, and the unused flag bits are cleared.
- R9: The registers update one clock edge after the operands are presented and `wr_en` is 1. When `wr_en` is 0, `result` and `flags_out` keep their values whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | Operation select (0 to 7, see requirements) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 8 | Current status byte |
| wr_en | input | 1 | Write strobe for the result and status registers |
| result | output | 8 | Registered result |
| flags_out | output | 8 | Registered status byte |

## Verification
On every cycle, the assertions check the following:
- the unused flag bits stay clear;
- the outputs hold while the strobe is low;
- Z, S and P agree with the registered result;
- increment and decrement keep the carry;
- complement and rotate relate the outputs to the previous operands.

Only the bench's scenarios can show that the sums, differences, borrows and nibble carries have the right values. The bench computes these values with integer arithmetic for the worked examples, for the wrap-around cases and for a spread of operand patterns.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic [7:0]   flags_in,
  input  logic         wr_en,
  output logic [W-1:0] result,
  output logic [7:0]   flags_out
);
  localparam int NB = W / 2;
  localparam logic [7:0] USED = 8'hD5;
  localparam logic [2:0] OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
                         OP_INC = 3'd4, OP_DEC = 3'd5, OP_CMA = 3'd6, OP_RLC = 3'd7;

  logic [W-1:0] b_eff;
  logic         cin;
  logic [W:0]   sum;
  logic [NB:0]  lo;
  logic [W-1:0] res_c;
  logic [7:0]   flg_c;
  logic         cy_c;
  logic         is_sub;

  assign is_sub = (op == OP_SUB) || (op == OP_SBB);

  always_comb begin
    b_eff = opnd_in;
    cin   = 1'b0;
    case (op)
      OP_ADC: cin = flags_in[0];
      OP_SUB: begin b_eff = ~opnd_in; cin = 1'b1; end
      OP_SBB: begin b_eff = ~opnd_in; cin = ~flags_in[0]; end
      OP_INC: b_eff = W'(1);
      OP_DEC: b_eff = {W{1'b1}};
      default: ;
    endcase
  end

  assign sum = {1'b0, acc_in} + {1'b0, b_eff} + (W+1)'(cin);
  assign lo  = {1'b0, acc_in[NB-1:0]} + {1'b0, b_eff[NB-1:0]} + (NB+1)'(cin);

  always_comb begin
    case (op)
      OP_CMA:  res_c = ~acc_in;
      OP_RLC:  res_c = {acc_in[W-2:0], acc_in[W-1]};
      default: res_c = sum[W-1:0];
    endcase
  end

  always_comb begin
    if (op == OP_INC || op == OP_DEC) cy_c = flags_in[0];
    else if (is_sub)                  cy_c = ~sum[W];
    else                              cy_c = sum[W];
  end

  always_comb begin
    case (op)
      OP_CMA:  flg_c = flags_in & USED;
      OP_RLC:  flg_c = {flags_in[7:1], acc_in[W-1]} & USED;
      default: flg_c = {res_c[W-1], ~|res_c, 1'b0, lo[NB], 1'b0, ~^res_c, 1'b0, cy_c};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      flags_out <= '0;
    end else if (wr_en) begin
      result    <= res_c;
      flags_out <= flg_c;
    end
  end
endmodule

module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op,
  input logic [W-1:0] acc_in,
  input logic [7:0]   flags_in,
  input logic         wr_en,
  input logic [W-1:0] result,
  input logic [7:0]   flags_out
);
  p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_out & 8'h2A) == 8'h00);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(result) && $stable(flags_out)));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op < 3'd6) |=> (flags_out[6] == (result == '0)));

  p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op < 3'd6) |=> (flags_out[7] == result[W-1]));

  p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op < 3'd6) |=> (flags_out[2] == ~^result));

  p_keep_cy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (op == 3'd4 || op == 3'd5)) |=> (flags_out[0] == $past(flags_in[0])));

  p_invert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == 3'd6) |=> (result == ~$past(acc_in)));

  p_rotate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == 3'd7) |=> (result[0] == $past(acc_in[W-1]) && flags_out[0] == $past(acc_in[W-1])));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .op(op), .acc_in(acc_in), .flags_in(flags_in),
  .wr_en(wr_en), .result(result), .flags_out(flags_out)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] acc_in = '0, opnd_in = '0, flags_in = '0;
  logic       wr_en = 1'b0;
  logic [7:0] result, flags_out;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] r; logic [7:0] f; string tag; } item_t;
  item_t sb[$];
  logic [15:0] last = '0;

  always #2.5 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst_n(rst_n), .op(op), .acc_in(acc_in), .opnd_in(opnd_in),
    .flags_in(flags_in), .wr_en(wr_en), .result(result), .flags_out(flags_out)
  );

  function automatic logic [15:0] model(input int o, input int a, input int b, input logic [7:0] fi);
    int t, ac, cy, r, lo;
    logic [7:0] f;
    cy = fi[0]; ac = 0;
    case (o)
      0, 1: begin
        lo = (o == 1) ? fi[0] : 0;
        t = a + b + lo; cy = (t > 255); ac = ((a % 16) + (b % 16) + lo) > 15; r = t % 256;
      end
      2, 3: begin
        lo = (o == 3) ? fi[0] : 0;
        t = a - b - lo; cy = (t < 0); ac = (a % 16) >= ((b % 16) + lo); r = (t + 512) % 256;
      end
      4: begin r = (a + 1) % 256; ac = (a % 16) == 15; end
      5: begin r = (a + 255) % 256; ac = (a % 16) != 0; end
      6: r = 255 - a;
      default: r = ((a * 2) % 256) + a / 128;
    endcase
    if (o == 6) return {r[7:0], fi & 8'hD5};
    if (o == 7) return {r[7:0], (fi & 8'hD4) | 8'(a / 128)};
    f = '0;
    f[7] = r[7]; f[6] = (r == 0); f[4] = ac[0]; f[2] = ~^r[7:0]; f[0] = cy[0];
    return {r[7:0], f};
  endfunction

  task automatic apply(input int o, input int a, input int b, input logic [7:0] fi, input string tag);
    item_t it;
    logic [15:0] e;
    @(negedge clk);
    op = 3'(o); acc_in = 8'(a); opnd_in = 8'(b); flags_in = fi; wr_en = 1'b1;
    e = model(o, a, b, fi);
    last = e;
    it.r = e[15:8]; it.f = e[7:0]; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int o, input int a, input int b, input logic [7:0] fi);
    item_t it;
    @(negedge clk);
    op = 3'(o); acc_in = 8'(a); opnd_in = 8'(b); flags_in = fi; wr_en = 1'b0;
    it.r = last[15:8]; it.f = last[7:0]; it.tag = "R9";
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      if (sb.size() > 0) begin
        #2;
        it = sb.pop_front();
        vectors++;
        if (result !== it.r || flags_out !== it.f) begin
          misses++;
          $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
                   it.tag, result, flags_out, it.r, it.f);
        end
      end
    end
  end

  initial begin : watchdog
    #500000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : driver
    #12;
    vectors++;
    if (result !== 8'h00 || flags_out !== 8'h00) begin
      misses++;
      $display("FAIL R1: result=%h flags=%h expected result=00 flags=00", result, flags_out);
    end
    @(negedge clk); rst_n = 1'b1;

    apply(0, 'h15, 'h27, 8'h00, "R2 add 15+27");
    apply(0, 'h30, 'h15, 8'h00, "R5 parity add 30+15");
    apply(0, 'h8A, 'h28, 8'h00, "R4 nibble carry 8A+28");
    apply(1, 'h4C, 'h25, 8'h01, "R2 adc 4C+25+1");
    apply(1, 'h2B, 'h58, 8'h00, "R2 adc 2B+58+0");
    apply(0, 'hFF, 'h01, 8'h00, "R2 carry out to zero");
    apply(0, 'h80, 'h80, 8'h00, "R5 zero with carry");
    apply(2, 'h15, 'h27, 8'h00, "R3 sub borrow 15-27");
    apply(2, 'h05, 'h02, 8'h00, "R3 sub 05-02");
    apply(2, 'h22, 'h22, 8'h00, "R5 sub equal zero");
    apply(3, 'h3A, 'h15, 8'h01, "R3 sbb 3A-15-1");
    apply(3, 'h29, 'h28, 8'h01, "R3 sbb to zero");
    apply(3, 'h00, 'hFF, 8'h01, "R4 sbb nibble borrow");
    apply(4, 'hFF, 'h00, 8'h00, "R6 inc FF wraps, CY kept 0");
    apply(4, 'h0F, 'h00, 8'h01, "R4 inc nibble, CY kept 1");
    apply(5, 'h00, 'h00, 8'h01, "R6 dec 00 wraps, CY kept 1");
    apply(5, 'h10, 'h00, 8'h00, "R4 dec nibble borrow");
    apply(5, 'h05, 'h00, 8'h00, "R4 dec no nibble borrow");
    apply(6, 'h5A, 'h00, 8'hFF, "R7 complement keeps flags");
    apply(6, 'h00, 'h33, 8'h00, "R7 complement zero");
    apply(7, 'h81, 'h00, 8'h00, "R8 rotate high bit");
    apply(7, 'h40, 'h00, 8'hD5, "R8 rotate clears CY");
    idle(0, 'hAA, 'h55, 8'h01);
    idle(7, 'h01, 'hFF, 8'hFF);
    apply(4, 'h7F, 'h00, 8'h00, "R9 update after hold");

    for (int i = 0; i < 120; i++) begin
      int a, b;
      a = (i * 37 + 11) % 256;
      b = (i * 91 + 200) % 256;
      apply(i % 8, a, b, 8'((i * 13) % 256), "R2 R3 R4 R5 sweep");
    end

    @(negedge clk); wr_en = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule